// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame. It has a single-entry data register and a frame shifter behind it. Software writes a character into the data register. The character moves into the shifter as soon as the shifter has nothing to send. The shifter then drives the line one bit per bit-tick interval: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The bit tick comes from a baud generator outside the block.

Two status flags report progress. The register-empty flag shows that a new character can be written. The send-done flag shows that the line has gone quiet with nothing left to send. Each flag drives its own interrupt line through its own enable. An acknowledge input stands for the processor entering the send-done interrupt routine and clears that flag. A status write port can also clear the send-done flag by writing a one to its bit. Writes to the register-empty bit position are ignored.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd_o` is 1, `dre_o` is 1 and `txc_o` is 0.
- R2: A write on `data_wr_i` while `dre_o` is 1 makes `dre_o` 0 from the next cycle on. `dre_o` becomes 1 again on the clock that moves the character into the shifter.
- R3: A write on `data_wr_i` while `dre_o` is 0 is dropped. `dre_o` stays 0 and the waiting character is neither replaced nor sent twice.
- R4: When the shifter is idle, a stored character moves into it on the next clock and `txd_o` stays 1. The start bit appears on `txd_o` on the clock that has the next `bit_tick_i` high.
- R5: A frame is a start bit of 0, then `DATA_W` data bits least significant first, then a parity bit if `par_en_i`=1, then one stop bit (`two_stop_i`=0) or two stop bits (`two_stop_i`=1) of value 1. Parity is the XOR of the data bits when `par_odd_i`=0 and its inverse when `par_odd_i`=1. Each bit is held from one tick clock to the next. The configuration is sampled when the character moves into the shifter.
- R6: If a character is waiting when the tick ending the last stop bit arrives, its start bit is driven on that same clock, and `txc_o` is not set.
- R7: `txc_o` becomes 1 on the clock after the tick that ends the last stop bit, if no character is waiting then.
- R8: `txc_o` is cleared on the clock after `txc_ack_i`=1, or after `stat_wr_i`=1 with `stat_wdata_i[1]`=1. A set in the same cycle takes priority over a clear.
- R9: `stat_wdata_i[0]`, the register-empty bit position, has no effect on `dre_o`.
- R10: `dre_irq_o` equals `dre_o & dre_ie_i`, so it stays asserted while the register is empty and enabled. `txc_irq_o` equals `txc_o & txc_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| data_wr_i | input | 1 | Write strobe for the data register |
| data_i | input | DATA_W | Character to send |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | Use odd parity instead of even |
| two_stop_i | input | 1 | Send two stop bits instead of one |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Status write data: bit 1 clears send-done, bit 0 is ignored |
| txc_ack_i | input | 1 | Send-done interrupt acknowledge |
| dre_ie_i | input | 1 | Register-empty interrupt enable |
| txc_ie_i | input | 1 | Send-done interrupt enable |
| dre_o | output | 1 | Register-empty flag |
| txc_o | output | 1 | Send-done flag |
| dre_irq_o | output | 1 | Register-empty interrupt |
| txc_irq_o | output | 1 | Send-done interrupt |
| txd_o | output | 1 | Serial output line |

## Verification
The hardest case to reach is the hand-off at the end of a frame. A character has to be waiting in the data register on exactly the tick that closes the last stop bit. Only then does the next start bit follow with no idle gap and the send-done flag stay clear. The stimulus reaches this case in two ways. Directed sequences write a second character right after the first one moves into the shifter, and a long random phase mixes tick spacing, write timing and frame settings. A cycle-accurate queue model checks every output on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Status write bit positions (decoded by the flag logic)
  localparam int unsigned STAT_DRE_BIT = 0;
  localparam int unsigned STAT_TXC_BIT = 1;
  localparam int unsigned STAT_W       = 2;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  always_comb begin
    accept = wr_i & ~full_q;
    full_d = (full_q & ~take_i) | accept;
    data_d = data_q;
    if (accept) data_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && wr_i) |=> full_q);

  a_r3_full_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr_i) |=> (data_q == $past(data_q)));

  a_r2_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && take_i) |=> !full_q);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  frame_cfg_t        cfg_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              take_o,
  output logic              end_empty_o,
  output logic              txd_o
);

  localparam int unsigned FW    = DATA_W + 4;
  localparam int unsigned CNT_W = $clog2(FW + 1);

  logic              active_q, active_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              txd_q, txd_d;
  logic [FW-1:0]     ld_vec;
  logic [CNT_W-1:0]  ld_len;
  logic              par_bit;
  logic              last_tick;

  // Frame image and length for the waiting character
  always_comb begin
    par_bit = (^hold_data_i) ^ cfg_i.par_odd;
    if (cfg_i.par_en) ld_vec = {2'b11, par_bit, hold_data_i, 1'b0};
    else              ld_vec = {3'b111, hold_data_i, 1'b0};
    ld_len = CNT_W'(DATA_W + 2)
           + {{(CNT_W-1){1'b0}}, cfg_i.par_en}
           + {{(CNT_W-1){1'b0}}, cfg_i.two_stop};
  end

  always_comb begin
    active_d    = active_q;
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    txd_d       = txd_q;
    last_tick   = active_q & tick_i & (cnt_q == '0);
    take_o      = (~active_q & hold_full_i) | (last_tick & hold_full_i);
    end_empty_o = last_tick & ~hold_full_i;
    if (!active_q) begin
      if (hold_full_i) begin
        active_d = 1'b1;
        sh_d     = ld_vec;
        cnt_d    = ld_len;
      end
    end else if (tick_i) begin
      if (cnt_q != '0) begin
        txd_d = sh_q[0];
        sh_d  = {1'b1, sh_q[FW-1:1]};
        cnt_d = cnt_q - 1'b1;
      end else if (hold_full_i) begin
        txd_d = ld_vec[0];
        sh_d  = {1'b1, ld_vec[FW-1:1]};
        cnt_d = ld_len - 1'b1;
      end else begin
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      cnt_q    <= '0;
      txd_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      if (take_o || (active_q && tick_i)) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
        txd_q <= txd_d;
      end
    end
  end

  assign txd_o = txd_q;

  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> txd_q);

  a_r4_no_move_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick_i) |=> $stable(txd_q));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r6_handoff_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && hold_full_i) |=> (!txd_q && active_q));

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              ack_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic              dre_i,
  input  logic              dre_ie_i,
  input  logic              txc_ie_i,
  output logic              txc_o,
  output logic              dre_irq_o,
  output logic              txc_irq_o
);

  logic txc_q, txc_d;
  logic clr;

  always_comb begin
    clr   = ack_i | (stat_wr_i & stat_wdata_i[STAT_TXC_BIT]);
    txc_d = txc_q;
    if (set_i)    txc_d = 1'b1;
    else if (clr) txc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b0;
    else        txc_q <= txc_d;
  end

  assign txc_o     = txc_q;
  assign dre_irq_o = dre_i & dre_ie_i;
  assign txc_irq_o = txc_q & txc_ie_i;

  a_r7_set_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> txc_q);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !txc_q);

  a_r8_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr) |=> (txc_q == $past(txc_q)));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              stat_wr_i,
  input  logic [1:0]        stat_wdata_i,
  input  logic              txc_ack_i,
  input  logic              dre_ie_i,
  input  logic              txc_ie_i,
  output logic              dre_o,
  output logic              txc_o,
  output logic              dre_irq_o,
  output logic              txc_irq_o,
  output logic              txd_o
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              end_empty;
  frame_cfg_t        cfg;

  assign cfg   = '{par_en: par_en_i, par_odd: par_odd_i, two_stop: two_stop_i};
  assign dre_o = ~hold_full;

  uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (data_wr_i),
    .wdata_i (data_i),
    .take_i  (take),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (bit_tick_i),
    .cfg_i       (cfg),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .end_empty_o (end_empty),
    .txd_o       (txd_o)
  );

  uart_tx_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (end_empty),
    .ack_i        (txc_ack_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .dre_i        (dre_o),
    .dre_ie_i     (dre_ie_i),
    .txc_ie_i     (txc_ie_i),
    .txc_o        (txc_o),
    .dre_irq_o    (dre_irq_o),
    .txc_irq_o    (txc_irq_o)
  );

  a_r9_dre_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && stat_wdata_i[STAT_DRE_BIT] && !data_wr_i && !take)
      |=> (dre_o == $past(dre_o)));

  a_r2_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !data_wr_i) |=> dre_o);

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_tick, data_wr, par_en, par_odd, two_stop;
  logic          stat_wr, txc_ack, dre_ie, txc_ie;
  logic [DW-1:0] data;
  logic [1:0]    stat_wdata;
  logic          dre, txc, dre_irq, txc_irq, txd;

  always #4 clk = ~clk;

  uart_tx_core #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick), .data_wr_i(data_wr),
    .data_i(data), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .txc_ack_i(txc_ack),
    .dre_ie_i(dre_ie), .txc_ie_i(txc_ie), .dre_o(dre), .txc_o(txc),
    .dre_irq_o(dre_irq), .txc_irq_o(txc_irq), .txd_o(txd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 0;

  // Reference model state
  bit   m_full, m_active, m_txd, m_txc;
  int   m_hold;
  bit   m_bits[$];
  int   sent_frames = 0;

  function automatic void build(int ch, bit pe, bit po, bit ts);
    bit p;
    p = po;
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < DW; i++) begin
      m_bits.push_back(ch[i]);
      p = p ^ ch[i];
    end
    if (pe) m_bits.push_back(p);
    m_bits.push_back(1'b1);
    if (ts) m_bits.push_back(1'b1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_active = 0; m_txd = 1; m_txc = 0; m_hold = 0;
      m_bits.delete();
    end else begin
      bit was_full, last, set_txc;
      was_full = m_full;
      last     = m_active && bit_tick && m_bits.size() == 0;
      set_txc  = last && !was_full;
      if (!m_active) begin
        if (was_full) begin
          build(m_hold, par_en, par_odd, two_stop);
          m_active = 1; m_full = 0;
        end
      end else if (bit_tick) begin
        if (m_bits.size() > 0) m_txd = m_bits.pop_front();
        else if (was_full) begin
          build(m_hold, par_en, par_odd, two_stop);
          m_txd = m_bits.pop_front();
          m_full = 0; sent_frames++;
        end else begin
          m_active = 0; sent_frames++;
        end
      end
      if (data_wr && !was_full) begin
        m_full = 1; m_hold = int'(data);
      end
      if (set_txc) m_txc = 1;
      else if (txc_ack || (stat_wr && stat_wdata[1])) m_txc = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd == m_txd, "R5 txd", txd, m_txd);
      chk(dre == !m_full, "R2 dre", dre, !m_full);
      chk(txc == m_txc, "R7 txc", txc, m_txc);
      chk(dre_irq == (!m_full && dre_ie), "R10 dre_irq", dre_irq, !m_full && dre_ie);
      chk(txc_irq == (m_txc && txc_ie), "R10 txc_irq", txc_irq, m_txc && txc_ie);
    end
  end

  // Tick generator
  int  tick_per = 5;
  bit  tick_rand = 0;
  int  tcnt = 0;
  always @(posedge clk) begin
    cyc++;
    #1;
    if (tick_rand) bit_tick = ($urandom_range(0, 3) == 0);
    else begin
      tcnt++;
      bit_tick = (tcnt >= tick_per);
      if (tcnt >= tick_per) tcnt = 0;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int ch);
    data_wr = 1; data = DW'(ch);
    step();
    data_wr = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((m_active || m_full) && guard < 5000) begin step(); guard++; end
    step(2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !ended) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; bit_tick = 0; data_wr = 0; data = '0; par_en = 0; par_odd = 0;
    two_stop = 0; stat_wr = 0; stat_wdata = '0; txc_ack = 0; dre_ie = 0; txc_ie = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(dre == 1'b1, "R1 dre", dre, 1);
    chk(txc == 1'b0, "R1 txc", txc, 0);
    rst_n = 1;
    step(2);

    // R4: idle transfer, line stays high until a tick
    dre_ie = 1; txc_ie = 1;
    tick_per = 40;
    wr(8'hA5);
    chk(dre == 1'b0, "R2 dre after write", dre, 0);
    step();
    chk(dre == 1'b1, "R4 dre after move", dre, 1);
    chk(txd == 1'b1, "R4 line high before tick", txd, 1);
    tick_per = 5;
    wait_idle();
    chk(txc == 1'b1, "R7 txc after frame", txc, 1);

    // R8: acknowledge clears
    txc_ack = 1; step(); txc_ack = 0;
    chk(txc == 1'b0, "R8 ack clears", txc, 0);

    // R3: second and third writes dropped while full
    wr(8'h3C);
    wr(8'hFF);            // transfer clock, register still full: dropped
    wr(8'h81);            // accepted after transfer
    wr(8'h00);            // dropped
    chk(dre == 1'b0, "R3 dre stays 0", dre, 0);
    wait_idle();
    chk(sent_frames == 3, "R3 frame count", sent_frames, 3);

    // R6: back-to-back with parity and two stop bits
    par_en = 1; par_odd = 1; two_stop = 1;
    wr(8'h17); step(); wr(8'h6E);
    wait_idle();
    par_odd = 0; two_stop = 0;
    wr(8'hC3); step(); wr(8'h5A);
    wait_idle();
    chk(txc == 1'b1, "R6 txc after pair", txc, 1);

    // R9: status write to dre bit ignored; R8 write-one clears txc
    stat_wr = 1; stat_wdata = 2'b01; step(); stat_wr = 0;
    chk(dre == 1'b1, "R9 dre unaffected", dre, 1);
    chk(txc == 1'b1, "R9 txc unaffected", txc, 1);
    stat_wr = 1; stat_wdata = 2'b10; step(); stat_wr = 0;
    chk(txc == 1'b0, "R8 write clears", txc, 0);
    wr(8'h44);
    stat_wr = 1; stat_wdata = 2'b01; step(); stat_wr = 0;
    wait_idle();

    // R10: enables gate interrupts
    dre_ie = 0; txc_ie = 0; step(3);
    chk(dre_irq == 1'b0, "R10 dre_irq off", dre_irq, 0);
    dre_ie = 1; txc_ie = 1; step();
    chk(dre_irq == 1'b1, "R10 dre_irq on", dre_irq, 1);

    // Random phase
    tick_rand = 1;
    for (int k = 0; k < 6000; k++) begin
      data_wr    = ($urandom_range(0, 9) == 0);
      data       = DW'($urandom);
      stat_wr    = ($urandom_range(0, 15) == 0);
      stat_wdata = 2'($urandom);
      txc_ack    = ($urandom_range(0, 19) == 0);
      dre_ie     = $urandom_range(0, 1) == 1;
      txc_ie     = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 63) == 0) begin
        par_en = $urandom_range(0, 1) == 1;
        par_odd = $urandom_range(0, 1) == 1;
        two_stop = $urandom_range(0, 1) == 1;
      end
      step();
    end
    data_wr = 0; stat_wr = 0; txc_ack = 0;
    wait_idle();
    finish_run();
  end

endmodule